// File: doc/BRIEF.md
# Zero-Suppressed Stub Block Packer

This block turns the stub slots of one bunch crossing into a single front data block of 16-bit words. Fifteen slots arrive from five sources, three slots per source. Each slot offers a valid bit, a sync-error bit and two 16-bit data frames. A start pulse samples all slot inputs, the active-source mask and the zero-suppression flag. The block then sends its words out over a valid/ready handshake. A last flag marks the final word, and a done pulse follows, so the framer knows it can move on to the next block.

Two masking rules act together. First, slots of inactive sources are removed entirely: their pattern bits read as zero and their frames are never sent. Second, when zero suppression is on, slots whose valid bit is clear are also skipped. Slot order never changes, so a block is 2 to 32 words long. When no source is active, no block is produced and only the done pulse appears.

Top module: `stub_block_packer`

## Requirements
- R1: After reset, out_valid, out_last, done and busy are all 0.
- R2: The first word of a block is the valid pattern. Bit i (0..14) holds the valid bit of slot i, and slot i belongs to source i/3. Bits of slots whose source has a 0 in src_active are forced to 0. Bit 15 is 0.
- R3: The second word is the sync-error pattern, in the same bit layout as R2 and with the same masking of inactive sources.
- R4: With zs_en at 0, every slot of every active source contributes frame 1 and then frame 2. Slots are taken in ascending slot index.
- R5: With zs_en at 1, a slot contributes its two frames only if its source is active and its valid bit is 1. The order is the same as in R4.
- R6: Bit 15 of every output word is 0. Frames are passed through with bit 15 cleared and bits 14..0 unchanged.
- R7: out_last is 1 only on the final word of a block. A block has between 2 and 32 words, and it has exactly 2 words when no slot contributes.
- R8: If src_active is 0 at start, no word is emitted, and done is 1 in the cycle after the start edge.
- R9: done is a single-cycle pulse in the cycle after the handshake of the last word. busy is 1 from the start edge until done drops.
- R10: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last stay unchanged.
- R11: Inputs are sampled only at an accepted start, so changing them afterwards has no effect. A start while busy is ignored, including one in the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Sample slots and begin a block (ignored while busy) |
| src_active | input | 5 | One bit per source; 1 = source is read out |
| zs_en | input | 1 | Zero suppression enable |
| slot_vld | input | 15 | Valid bit per slot |
| slot_serr | input | 15 | Sync-error bit per slot |
| slot_fr1 | input | 240 | Frame 1 of each slot, slot i at bits 16i+15..16i |
| slot_fr2 | input | 240 | Frame 2 of each slot, same packing |
| out_data | output | 16 | Output word |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Consumer accepts the word |
| out_last | output | 1 | Current word is the last of the block |
| done | output | 1 | Pulse after the block (or after an empty start) |
| busy | output | 1 | Block in progress |

## Verification
Two events can land in the same cycle: the completion of a block (the done pulse) and a new start request. The bench pulses start exactly in the done cycle, and again in the middle of a block with different slot contents. Either start must be dropped. This is judged by the scoreboard: any word it did not predict counts as a failure, and so does a block that does not leave busy low and the expected queue empty afterwards. The last-word handshake is also combined with random backpressure, to confirm that the done pulse still follows exactly one cycle after the final accepted word.

// File: rtl/stub_pack_pkg.sv
package stub_pack_pkg;
   typedef enum logic [2:0] {
      PK_IDLE,
      PK_VPAT,
      PK_SPAT,
      PK_FRA,
      PK_FRB,
      PK_DONE
   } pk_state_t;
endpackage

// File: rtl/stub_mask.sv
module stub_mask #(
   parameter int N_SRC         = 5,
   parameter int SLOTS_PER_SRC = 3,
   localparam int N_SLOT       = N_SRC * SLOTS_PER_SRC
) (
   input  logic [N_SRC-1:0]  src_active,
   input  logic              zs_en,
   input  logic [N_SLOT-1:0] slot_vld,
   input  logic [N_SLOT-1:0] slot_serr,
   output logic [N_SLOT-1:0] vp_m,
   output logic [N_SLOT-1:0] se_m,
   output logic [N_SLOT-1:0] incl
);
   for (genvar s = 0; s < N_SRC; s++) begin : g_src
      for (genvar k = 0; k < SLOTS_PER_SRC; k++) begin : g_slot
         localparam int IDX = s * SLOTS_PER_SRC + k;
         assign vp_m[IDX] = slot_vld[IDX]  & src_active[s];
         assign se_m[IDX] = slot_serr[IDX] & src_active[s];
         assign incl[IDX] = src_active[s] & (~zs_en | slot_vld[IDX]);
      end
   end
endmodule

// File: rtl/stub_prio.sv
module stub_prio #(
   parameter int N  = 15,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [IW-1:0] idx,
   output logic          any,
   output logic          single
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
   assign any    = |req;
   assign single = any && ((req & (req - N'(1))) == '0);
endmodule

// File: rtl/stub_block_packer.sv
module stub_block_packer
   import stub_pack_pkg::*;
#(
   parameter int N_SRC         = 5,
   parameter int SLOTS_PER_SRC = 3,
   parameter int W             = 16,
   localparam int N_SLOT       = N_SRC * SLOTS_PER_SRC,
   localparam int IW           = (N_SLOT > 1) ? $clog2(N_SLOT) : 1,
   localparam int MAX_WORDS    = 2 * N_SLOT + 2,
   localparam int CW           = $clog2(MAX_WORDS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [N_SRC-1:0]    src_active,
   input  logic                zs_en,
   input  logic [N_SLOT-1:0]   slot_vld,
   input  logic [N_SLOT-1:0]   slot_serr,
   input  logic [N_SLOT*W-1:0] slot_fr1,
   input  logic [N_SLOT*W-1:0] slot_fr2,
   output logic [W-1:0]        out_data,
   output logic                out_valid,
   input  logic                out_ready,
   output logic                out_last,
   output logic                done,
   output logic                busy
);
   if (N_SLOT > W - 1) begin : g_chk_width
      $error("pattern words need N_SLOT < W");
   end
   if (N_SRC < 1 || SLOTS_PER_SRC < 1) begin : g_chk_count
      $error("need at least one source and one slot");
   end

   pk_state_t           st_q;
   logic [N_SLOT-1:0]   vp_m, se_m, incl;
   logic [N_SLOT-1:0]   vp_q, se_q, pend_q;
   logic [W-1:0]        fra_q [N_SLOT];
   logic [W-1:0]        frb_q [N_SLOT];
   logic [IW-1:0]       cur;
   logic                any_pend, one_pend, hs;
   logic [CW-1:0]       wcnt_q;

   stub_mask #(.N_SRC(N_SRC), .SLOTS_PER_SRC(SLOTS_PER_SRC)) u_mask (
      .src_active(src_active), .zs_en(zs_en), .slot_vld(slot_vld),
      .slot_serr(slot_serr), .vp_m(vp_m), .se_m(se_m), .incl(incl)
   );

   stub_prio #(.N(N_SLOT)) u_prio (
      .req(pend_q), .idx(cur), .any(any_pend), .single(one_pend)
   );

   assign out_valid = (st_q == PK_VPAT) || (st_q == PK_SPAT) ||
                      (st_q == PK_FRA)  || (st_q == PK_FRB);
   assign hs        = out_valid && out_ready;
   assign done      = (st_q == PK_DONE);
   assign busy      = (st_q != PK_IDLE);
   assign out_last  = ((st_q == PK_SPAT) && !any_pend) ||
                      ((st_q == PK_FRB)  && one_pend);

   always_comb begin
      unique case (st_q)
         PK_VPAT: out_data = {{(W-N_SLOT){1'b0}}, vp_q};
         PK_SPAT: out_data = {{(W-N_SLOT){1'b0}}, se_q};
         PK_FRA:  out_data = {1'b0, fra_q[cur][W-2:0]};
         PK_FRB:  out_data = {1'b0, frb_q[cur][W-2:0]};
         default: out_data = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= PK_IDLE;
         vp_q   <= '0;
         se_q   <= '0;
         pend_q <= '0;
      end else begin
         unique case (st_q)
            PK_IDLE: if (start) begin
               vp_q   <= vp_m;
               se_q   <= se_m;
               pend_q <= incl;
               st_q   <= (|src_active) ? PK_VPAT : PK_DONE;
            end
            PK_VPAT: if (hs) st_q <= PK_SPAT;
            PK_SPAT: if (hs) st_q <= any_pend ? PK_FRA : PK_DONE;
            PK_FRA:  if (hs) st_q <= PK_FRB;
            PK_FRB:  if (hs) begin
               pend_q <= pend_q & ~(N_SLOT'(1) << cur);
               st_q   <= one_pend ? PK_DONE : PK_FRA;
            end
            default: st_q <= PK_IDLE;
         endcase
      end
   end

   for (genvar i = 0; i < N_SLOT; i++) begin : g_cap
      always_ff @(posedge clk) begin
         if (st_q == PK_IDLE && start) begin
            fra_q[i] <= slot_fr1[i*W +: W];
            frb_q[i] <= slot_fr2[i*W +: W];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || st_q == PK_IDLE) wcnt_q <= '0;
      else if (hs)                   wcnt_q <= wcnt_q + CW'(1);
   end

   a_r10_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
   a_r6_msb_zero: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !out_data[W-1]);
   a_r7_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);
   a_r7_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> wcnt_q < CW'(MAX_WORDS));
   a_r9_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
      hs && out_last |=> done);
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy);
   a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !done && !hs |=> busy);
endmodule

// File: tb/sim_stub_block_packer.sv
module sim_stub_block_packer;
   localparam int CLK_PERIOD = 10;

   logic clk = 0, rst_n = 0, start = 0, zs_en = 0, out_ready = 1;
   logic [4:0] src_active = '0;
   logic [14:0] slot_vld = '0, slot_serr = '0;
   logic [239:0] slot_fr1 = '0, slot_fr2 = '0;
   logic [15:0] out_data;
   logic out_valid, out_last, done, busy;

   stub_block_packer u0 (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   int total = 0, bad = 0, cycles = 0;
   bit finished = 0, rdy_rand = 0;
   logic [16:0] exp_q [$];
   string cur_req = "R4";
   int widx = 0;
   bit last_seen = 0, stall_seen = 0;
   logic [16:0] stall_word;
   logic [15:0] lfsr = 16'hACE1;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      #1;
      if (rdy_rand) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         out_ready = lfsr[0] | lfsr[3];
      end else out_ready = 1;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (last_seen) chk(done === 1'b1, "R9", done, 1);
         if (stall_seen) chk(out_valid && {out_last, out_data} === stall_word, "R10",
                             {out_valid, out_last, out_data}, {1'b1, stall_word});
         last_seen  = 0;
         stall_seen = out_valid && !out_ready;
         stall_word = {out_last, out_data};
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) chk(0, "R11", {out_last, out_data}, 0);
            else begin
               logic [16:0] e;
               e = exp_q.pop_front();
               chk({out_last, out_data} === e, (widx == 0) ? "R2" : (widx == 1) ? "R3" : cur_req,
                   {out_last, out_data}, e);
               chk(out_last === e[16], "R7", out_last, e[16]);
            end
            chk(out_data[15] === 1'b0, "R6", out_data, 0);
            widx++;
            if (out_last) begin
               widx = 0;
               last_seen = 1;
            end
         end
      end
   end

   task automatic run_block(input logic [4:0] act, input bit zs, input logic [14:0] vld,
                            input logic [14:0] se, input logic [239:0] f1, input logic [239:0] f2,
                            input bit mid_start);
      logic [15:0] w [$];
      logic [14:0] vm, sm;
      for (int i = 0; i < 15; i++) begin
         vm[i] = vld[i] & act[i/3];
         sm[i] = se[i] & act[i/3];
      end
      cur_req = zs ? "R5" : "R4";
      if (act != 0) begin
         w.push_back({1'b0, vm});
         w.push_back({1'b0, sm});
         for (int i = 0; i < 15; i++)
            if (act[i/3] && (!zs || vld[i])) begin
               w.push_back({1'b0, f1[i*16 +: 15]});
               w.push_back({1'b0, f2[i*16 +: 15]});
            end
         for (int i = 0; i < w.size(); i++) exp_q.push_back({i == w.size() - 1, w[i]});
      end
      @(negedge clk);
      src_active = act; zs_en = zs; slot_vld = vld; slot_serr = se;
      slot_fr1 = f1; slot_fr2 = f2; start = 1;
      @(negedge clk);
      start = 0;
      src_active = ~act; zs_en = ~zs; slot_vld = ~vld; slot_serr = ~se;
      slot_fr1 = ~f1; slot_fr2 = ~f2;
      if (act == 0) begin
         chk(done === 1'b1 && out_valid === 1'b0, "R8", {done, out_valid}, 2'b10);
         @(negedge clk);
         chk(out_valid === 1'b0 && busy === 1'b0, "R8", {out_valid, busy}, 0);
      end else begin
         chk(busy === 1'b1, "R9", busy, 1);
         for (int n = 0; n < 3000 && done !== 1'b1; n++) begin
            start = (mid_start && n == 3);
            @(negedge clk);
         end
         start = 1;          // start in the done cycle must be dropped (R11)
         @(negedge clk);
         start = 0;
         chk(busy === 1'b0 && exp_q.size() == 0, "R11", {busy, 8'(exp_q.size())}, 0);
      end
   endtask

   function automatic logic [239:0] mkfr(input logic [15:0] seed);
      logic [239:0] r;
      for (int i = 0; i < 15; i++) r[i*16 +: 16] = seed + 16'(i * 16'h0111) ^ ((i % 2) ? 16'h8000 : 16'h0);
      return r;
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      chk(out_valid === 0 && out_last === 0 && done === 0 && busy === 0, "R1",
          {out_valid, out_last, done, busy}, 0);
      rst_n = 1;
      run_block(5'b11111, 0, 15'h2A5C, 15'h1234, mkfr(16'h0100), mkfr(16'h4200), 0);
      rdy_rand = 1;
      run_block(5'b11111, 1, 15'h2A5C, 15'h7001, mkfr(16'h0300), mkfr(16'h0E00), 0);
      run_block(5'b00101, 1, 15'h7FFF, 15'h7FFF, mkfr(16'h1000), mkfr(16'h2000), 1);
      run_block(5'b10000, 1, 15'h0FFF, 15'h4000, mkfr(16'h0050), mkfr(16'h0060), 0);
      run_block(5'b00000, 0, 15'h7FFF, 15'h7FFF, mkfr(16'h0001), mkfr(16'h0002), 0);
      run_block(5'b01010, 0, 15'h0000, 15'h5555, mkfr(16'hF000), mkfr(16'hC00F), 1);
      run_block(5'b11111, 1, 15'h7FFF, 15'h0000, mkfr(16'h7777), mkfr(16'h3333), 0);
      rdy_rand = 0;
      run_block(5'b00001, 1, 15'h0005, 15'h0002, mkfr(16'h0A0A), mkfr(16'h0B0B), 0);
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      wait (cycles > 150000);
      if (!finished) begin
         finished = 1;
         chk(0, "R9", cycles, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule